// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for a four-beat burst into a synchronous memory. A base address is captured on a clock edge when either of two load strobes is low. One strobe comes from the processor side and the other from the controller side. After the capture, the upper address bits stay at the captured value. A two-bit beat counter then forms the two low address bits from the captured start bits.

The counter moves forward only on cycles where the active-low advance input is low and no strobe is low. When advance is high, the burst is suspended and the address holds. After the fourth beat, the next advance wraps back to the start address; it does not stop.

A static mode pin selects the order of the beats. In linear order the low bits count up modulo four. In interleaved order the low bits are the start bits XOR the beat number. A flag marks the fourth beat. The memory array, the data path and chip-select decoding sit outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the held address, the start bits and the beat number, so `addr_out` is 0 and `last_beat` is 0 from the next cycle on.
- R2: At a clock edge where `load_cpu_n` or `load_ctl_n` is 0, `base_addr` is captured. From the next cycle on, `addr_out` equals that base and the beat number is 0.
- R3: When a strobe is low in the same cycle as `adv_n`, the load takes priority and the advance has no effect.
- R4: With `mode_lin` = 1, each advance-only edge moves to the next beat n. `addr_out[1:0]` is then (start + n) mod 4.
- R5: With `mode_lin` = 0, `addr_out[1:0]` on beat n is start XOR n, so bit 0 toggles on every advance.
- R6: At an edge where both strobes and `adv_n` are 1, `addr_out` and `last_beat` keep their values (the burst is suspended).
- R7: `addr_out[ADDR_W-1:2]` holds the captured base bits while the burst advances. The counter never carries into them.
- R8: The advance after beat 3 returns to beat 0, so `addr_out[1:0]` equals the start bits again.
- R9: `last_beat` is 1 exactly on beat 3 of the burst and 0 on beats 0 to 2.
- R10: A low `load_ctl_n` in the middle of a burst restarts the burst from the new base at beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_cpu_n | input | 1 | Processor-side load strobe, active low |
| load_ctl_n | input | 1 | Controller-side load strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| mode_lin | input | 1 | Burst order, static: 1 = linear, 0 = interleaved |
| base_addr | input | ADDR_W | Base address captured on a load |
| addr_out | output | ADDR_W | Current burst address |
| last_beat | output | 1 | High on the fourth beat |

## Verification
Directed bursts run in each order from start values that expose the difference between adding and XOR: a linear burst from start 2 gives 2,3,0,1, and an interleaved burst from start 1 gives 1,0,3,2. Both bursts continue past the fourth beat to show the wrap. Further directed cases place a suspension in the middle of a burst, assert both strobes together with advance, and reload from the controller strobe half-way through a burst. These cases separate load priority from counting. A long run of random strobe, advance and base patterns follows in both modes, with the mode changed only during reset. A bench model predicts every address and flag in that run, and the high base bits check that no carry leaks out of the counter.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_cpu_n,
  input  logic              load_ctl_n,
  input  logic              adv_n,
  input  logic              mode_lin,
  input  logic [ADDR_W-1:0] base_addr,
  output logic [ADDR_W-1:0] addr_out,
  output logic              last_beat
);
  localparam int LOW_W = 2;
  localparam int UP_W  = ADDR_W - LOW_W;

  logic [UP_W-1:0]  up_q;
  logic [LOW_W-1:0] start_q;
  logic [LOW_W-1:0] beat_q;
  logic [LOW_W-1:0] low;
  logic             load;
  logic             step;

  assign load = !load_cpu_n || !load_ctl_n;
  assign step = !load && !adv_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q    <= '0;
      start_q <= '0;
      beat_q  <= '0;
    end else if (load) begin
      up_q    <= base_addr[ADDR_W-1:LOW_W];
      start_q <= base_addr[LOW_W-1:0];
      beat_q  <= '0;
    end else if (step) begin
      beat_q  <= beat_q + 1'b1;
    end
  end

  assign low       = mode_lin ? (start_q + beat_q) : (start_q ^ beat_q);
  assign addr_out  = {up_q, low};
  assign last_beat = (beat_q == 2'd3);

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (addr_out == '0 && !last_beat));

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (addr_out == $past(base_addr) && !last_beat));

  assert_load_prio_R3: assert property (@(posedge clk) disable iff (rst)
    (load && !adv_n) |=> (addr_out[LOW_W-1:0] == $past(base_addr[LOW_W-1:0])));

  assert_linear_step_R4: assert property (@(posedge clk) disable iff (rst)
    (step && mode_lin) |=> (addr_out[LOW_W-1:0] == $past(addr_out[LOW_W-1:0]) + 2'd1));

  assert_interleave_step_R5: assert property (@(posedge clk) disable iff (rst)
    (step && !mode_lin) |=> (addr_out[0] != $past(addr_out[0])));

  assert_suspend_R6: assert property (@(posedge clk) disable iff (rst)
    (!load && adv_n) |=> ($stable(addr_out) && $stable(last_beat)));

  assert_upper_R7: assert property (@(posedge clk) disable iff (rst)
    step |=> (addr_out[ADDR_W-1:LOW_W] == $past(addr_out[ADDR_W-1:LOW_W])));

  assert_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (step && last_beat) |=> (addr_out[LOW_W-1:0] == start_q && !last_beat));

  assert_last_R9: assert property (@(posedge clk) disable iff (rst)
    (step && !last_beat && $past(step) && $past(last_beat)) |=> !last_beat);

  assert_reload_R10: assert property (@(posedge clk) disable iff (rst)
    (!load_ctl_n && !load_cpu_n == 1'b0 && last_beat) |=> (addr_out == $past(base_addr) && !last_beat));
endmodule

// File: tb/tb_burst_addr_gen.sv
`timescale 1ns/1ps
module tb_burst_addr_gen;
  localparam int AW = 15;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_cpu_n = 1'b1;
  logic          load_ctl_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          mode_lin = 1'b1;
  logic [AW-1:0] base_addr = '0;
  logic [AW-1:0] addr_out;
  logic          last_beat;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [AW-3:0] m_up = '0;
  logic [1:0]    m_start = '0;
  logic [1:0]    m_n = '0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .load_cpu_n(load_cpu_n), .load_ctl_n(load_ctl_n),
    .adv_n(adv_n), .mode_lin(mode_lin), .base_addr(base_addr),
    .addr_out(addr_out), .last_beat(last_beat)
  );

  function automatic logic [1:0] exp_low(input logic [1:0] s, input logic [1:0] n, input logic lin);
    return lin ? 2'(s + n) : (s ^ n);
  endfunction

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic cpu_n, input logic ctl_n,
                      input logic a_n, input logic [AW-1:0] b, input string tag);
    logic [AW-1:0] exp_addr;
    logic          mid;
    rst = r; load_cpu_n = cpu_n; load_ctl_n = ctl_n; adv_n = a_n; base_addr = b;
    mid = (m_n != 2'd0);
    @(posedge clk);
    if (r) begin
      m_up = '0; m_start = '0; m_n = '0;
    end else if (!cpu_n || !ctl_n) begin
      m_up = b[AW-1:2]; m_start = b[1:0]; m_n = '0;
    end else if (!a_n) begin
      m_n = m_n + 2'd1;
    end
    @(negedge clk);
    exp_addr = {m_up, exp_low(m_start, m_n, mode_lin)};
    if (!ctl_n && mid && !r) check("R10 mid-burst reload", addr_out, exp_addr);
    else check(tag, addr_out, exp_addr);
    check("R9 last beat flag", AW'(last_beat), AW'(m_n == 2'd3));
    check("R7 upper bits", AW'(addr_out[AW-1:2]), AW'(m_up));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    @(negedge clk);
    step(1'b1, 1'b1, 1'b1, 1'b1, '0, "R1 reset");
    check("R1 reset address", addr_out, '0);

    mode_lin = 1'b1;
    step(1'b0, 1'b0, 1'b1, 1'b1, 15'h1A62, "R2 cpu load");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1, 1'b0, '0, "R4 linear step");
    step(1'b0, 1'b1, 1'b1, 1'b0, '0, "R8 linear wrap");
    check("R8 wrap to start", addr_out, 15'h1A62);
    step(1'b0, 1'b1, 1'b1, 1'b1, '0, "R6 suspend");
    step(1'b0, 1'b1, 1'b1, 1'b1, '0, "R6 suspend again");
    step(1'b0, 1'b0, 1'b0, 1'b0, 15'h0735, "R3 both strobes with advance");
    check("R3 load beats advance", addr_out, 15'h0735);
    step(1'b0, 1'b1, 1'b1, 1'b0, '0, "R4 linear step");
    step(1'b0, 1'b1, 1'b0, 1'b0, 15'h7FFF, "R10 ctl reload");
    step(1'b0, 1'b1, 1'b1, 1'b0, '0, "R7 no carry");
    check("R7 no carry into upper", addr_out, 15'h7FFC);

    step(1'b1, 1'b1, 1'b1, 1'b1, '0, "R1 reset");
    mode_lin = 1'b0;
    step(1'b1, 1'b1, 1'b1, 1'b1, '0, "R1 reset");
    step(1'b0, 1'b1, 1'b0, 1'b1, 15'h2221, "R2 ctl load");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1, 1'b0, '0, "R5 interleaved step");
    check("R5 interleaved beat 3", addr_out, 15'h2222);
    step(1'b0, 1'b1, 1'b1, 1'b0, '0, "R8 interleaved wrap");

    for (int ph = 0; ph < 2; ph++) begin
      step(1'b1, 1'b1, 1'b1, 1'b1, '0, "R1 reset");
      mode_lin = ph[0];
      step(1'b1, 1'b1, 1'b1, 1'b1, '0, "R1 reset");
      for (int i = 0; i < 3000; i++) begin
        logic cpu_n, ctl_n, a_n;
        cpu_n = ($urandom % 8) != 0;
        ctl_n = ($urandom % 8) != 0;
        a_n   = ($urandom % 4) == 0;
        step(($urandom % 500) == 0, cpu_n, ctl_n, a_n, AW'($urandom),
             mode_lin ? "R4 random linear" : "R5 random interleaved");
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule